// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Event Interrupts

This block is a byte-addressed general-purpose I/O controller serving up to sixteen pins. Software reaches it over a plain 8-bit register bus. Each pin can be an input or an output, and the block keeps an output value for each pin. Pin levels pass through a two-stage synchroniser. They can then be read back, and the same samples feed a per-pin event detector.

Each pin selects one of four trigger kinds with two bits: rising edge, falling edge, high level or low level. A detected event sets a sticky status bit. Writing a one to that bit clears it. An enable mask decides which pending events drive the single interrupt output.

The number of implemented pins is a build parameter. Software can discover it from the mode register, because the mode bits of absent pins always read back as one. A second build parameter decides where the output values live. They can sit in a register of their own, or share the address of the line-level register.

The register bus has no flow control. A write completes at the clock edge that samples the write strobe. Read data is a combinational function of the address, so no valid/ready handshake and no back-pressure apply.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: Every control word is 16 bits wide and is split over two byte addresses. The even address (base) holds pins 0 to 7 and base+1 holds pins 8 to 15. The bases are: 0x40 direction, 0x42 line level, 0x44 status, 0x46 mode (edge/level), 0x48 polarity, 0x4A interrupt enable, 0x4E output value. A write to one byte leaves the other byte of the same word unchanged.
- R2: A direction bit of 1 makes the pin an output, so the matching `pin_oe` bit is 1. A direction bit of 0 makes it an input.
- R3: With `SPLIT_OUT`=1, the output value is read and written at 0x4E/0x4F and drives `pin_out`. In this mode, writes to 0x42/0x43 have no effect.
- R4: With `SPLIT_OUT`=0, writes to 0x42/0x43 load the output value that drives `pin_out`. Reads of 0x42/0x43 still return the pin level. Addresses 0x4E/0x4F are then unmapped.
- R5: Reads of 0x42/0x43 return the pin inputs after a two-flop synchroniser. Bits of unimplemented pins read 0.
- R6: With its mode bit at 1, a pin is edge-triggered. A polarity bit of 1 sets status on a 0-to-1 change of the synchronised level, and a polarity bit of 0 sets it on a 1-to-0 change.
- R7: With its mode bit at 0, a pin is level-triggered. A polarity bit of 1 means high and 0 means low. The status bit is set again on every cycle the active level is present.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event in the same cycle as the clear wins, so the bit stays set.
- R9: `irq` is 1 exactly while some status bit is set whose interrupt-enable bit is also set.
- R10: Mode bits of pins at or above `PIN_COUNT` always read 1, whatever was written. With `PIN_COUNT`=16 the mode register reads back exactly what was written. In all other registers, bits of unimplemented pins read 0.
- R11: Writes to addresses outside the map have no effect, and reads from such addresses return 0x00.
- R12: Reset clears every register. After reset all pins are inputs, every pin is in low-level mode, and both the enable and status registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the addressed byte |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Output values toward the pads |
| pin_oe | output | 16 | Output enables (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The event detector is driven with four patterns, one for each trigger kind. A rising pulse on a rising-edge pin must set status once, and the return to low must not set it again. A pulse on a falling-edge pin must set status only on its trailing edge. A held level on a level-high pin must set status again straight after a clear, which separates level behaviour from edge behaviour.

The pin levels used for readback (0x5A3C on a 12-pin build) show three things: byte-lane order, masking of absent pins, and the synchroniser path. Clear writes of all zeros, of a single one and of all ones separate write-one-to-clear from a plain store. A 16-pin shared-output build is compared against a 12-pin dedicated-output build, which tells apart the two output register variants and the discovery read-back.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int GPIO_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [7:0] A_DIR  = 8'h40;
  localparam logic [7:0] A_LVL  = 8'h42;
  localparam logic [7:0] A_STAT = 8'h44;
  localparam logic [7:0] A_MODE = 8'h46;
  localparam logic [7:0] A_POL  = 8'h48;
  localparam logic [7:0] A_IEN  = 8'h4A;
  localparam logic [7:0] A_OUT  = 8'h4E;

  typedef enum logic [2:0] {
    RG_DIR, RG_LVL, RG_STAT, RG_MODE, RG_POL, RG_IEN, RG_OUT, RG_NONE
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     hi;
  } reg_dec_t;

  // Word address is addr[7:1]; addr[0] picks the upper byte lane.
  function automatic reg_dec_t decode_addr(input logic [7:0] a, input logic split_out);
    reg_dec_t d;
    d.hi = a[0];
    case (a[7:1])
      A_DIR[7:1]:  d.sel = RG_DIR;
      A_LVL[7:1]:  d.sel = RG_LVL;
      A_STAT[7:1]: d.sel = RG_STAT;
      A_MODE[7:1]: d.sel = RG_MODE;
      A_POL[7:1]:  d.sel = RG_POL;
      A_IEN[7:1]:  d.sel = RG_IEN;
      A_OUT[7:1]:  d.sel = split_out ? RG_OUT : RG_NONE;
      default:     d.sel = RG_NONE;
    endcase
    return d;
  endfunction

  function automatic logic [GPIO_W-1:0] put_byte(input logic [GPIO_W-1:0] cur,
                                                 input logic hi,
                                                 input logic [BYTE_W-1:0] b);
    return hi ? {b, cur[BYTE_W-1:0]} : {cur[GPIO_W-1:BYTE_W], b};
  endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int           W    = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol_sel,
  output logic [W-1:0] hit
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (IMPL[i]) begin : g_live
      logic h;
      always_comb begin
        case ({edge_sel[i], pol_sel[i]})
          2'b11:   h = lvl[i] & ~prev_q[i];
          2'b10:   h = ~lvl[i] & prev_q[i];
          2'b01:   h = lvl[i];
          default: h = ~lvl[i];
        endcase
      end
      assign hit[i] = h;
    end else begin : g_absent
      assign hit[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter bit SPLIT_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  reg_dec_t          dec,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [GPIO_W-1:0] lvl,
  input  logic [GPIO_W-1:0] hit,
  output logic [BYTE_W-1:0] rdata,
  output logic [GPIO_W-1:0] dir_q,
  output logic [GPIO_W-1:0] out_q,
  output logic [GPIO_W-1:0] mode_q,
  output logic [GPIO_W-1:0] pol_q,
  output logic [GPIO_W-1:0] stat_q,
  output logic              irq
);

  localparam logic [GPIO_W-1:0] IMPL = GPIO_W'((32'd1 << PIN_COUNT) - 32'd1);

  logic [GPIO_W-1:0] ien_q;
  logic [GPIO_W-1:0] wr_word;
  logic [GPIO_W-1:0] clr_mask;
  logic [GPIO_W-1:0] rd_word;
  logic              out_we;

  if (SPLIT_OUT) begin : g_out_own
    assign out_we = we && (dec.sel == RG_OUT);
  end else begin : g_out_shared
    assign out_we = we && (dec.sel == RG_LVL);
  end

  always_comb begin
    unique case (dec.sel)
      RG_DIR:  wr_word = put_byte(dir_q,  dec.hi, wdata);
      RG_MODE: wr_word = put_byte(mode_q, dec.hi, wdata);
      RG_POL:  wr_word = put_byte(pol_q,  dec.hi, wdata);
      RG_IEN:  wr_word = put_byte(ien_q,  dec.hi, wdata);
      default: wr_word = put_byte(out_q,  dec.hi, wdata);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (we) begin
      case (dec.sel)
        RG_DIR:  dir_q  <= wr_word & IMPL;
        RG_MODE: mode_q <= wr_word & IMPL;
        RG_POL:  pol_q  <= wr_word & IMPL;
        RG_IEN:  ien_q  <= wr_word & IMPL;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_we) out_q <= wr_word & IMPL;
  end

  always_comb begin
    clr_mask = '0;
    if (we && dec.sel == RG_STAT)
      clr_mask = dec.hi ? {wdata, 8'h00} : {8'h00, wdata};
  end

  // A new event in the clearing cycle keeps its bit set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr_mask) | hit) & IMPL;
  end

  always_comb begin
    case (dec.sel)
      RG_DIR:  rd_word = dir_q;
      RG_LVL:  rd_word = lvl & IMPL;
      RG_STAT: rd_word = stat_q;
      RG_MODE: rd_word = mode_q | ~IMPL;
      RG_POL:  rd_word = pol_q;
      RG_IEN:  rd_word = ien_q;
      RG_OUT:  rd_word = out_q;
      default: rd_word = '0;
    endcase
    rdata = dec.hi ? rd_word[GPIO_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
  end

  assign irq = |(stat_q & ien_q);

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter bit SPLIT_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [15:0] pin_in,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe,
  output logic        irq
);

  localparam logic [GPIO_W-1:0] IMPL = GPIO_W'((32'd1 << PIN_COUNT) - 32'd1);

  reg_dec_t          dec;
  logic [GPIO_W-1:0] lvl_s;
  logic [GPIO_W-1:0] evt_hit;
  logic [GPIO_W-1:0] stat_q;
  logic [GPIO_W-1:0] mode_q;
  logic [GPIO_W-1:0] pol_q;

  assign dec = decode_addr(reg_addr, SPLIT_OUT);

  gpio_evt_sync #(.W(GPIO_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (lvl_s)
  );

  gpio_evt_detect #(.W(GPIO_W), .IMPL(IMPL)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl_s),
    .edge_sel (mode_q),
    .pol_sel  (pol_q),
    .hit      (evt_hit)
  );

  gpio_evt_regs #(.PIN_COUNT(PIN_COUNT), .SPLIT_OUT(SPLIT_OUT)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .dec    (dec),
    .wdata  (reg_wdata),
    .lvl    (lvl_s),
    .hit    (evt_hit),
    .rdata  (reg_rdata),
    .dir_q  (pin_oe),
    .out_q  (pin_out),
    .mode_q (mode_q),
    .pol_q  (pol_q),
    .stat_q (stat_q),
    .irq    (irq)
  );

endmodule

// File: rtl/gpio_evt_ctrl_chk.sv
module gpio_evt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic [7:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [15:0] pin_oe,
  input logic        irq,
  input logic [15:0] status_vec,
  input logic [15:0] hit_vec
);

  // R1: a low-byte direction write keeps the upper lane
  p_lane_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h40) |=> $stable(pin_oe[15:8]));

  // R6: a detected event is captured in status on the next edge
  p_hit_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != 16'h0) |=> ((status_vec & $past(hit_vec)) == $past(hit_vec)));

  // R7: a status bit only turns on where the detector fired
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((status_vec & ~$past(status_vec)) & ~$past(hit_vec)) == 16'h0));

  // R8: an all-ones clear empties the low lane when nothing new arrives
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h44 && wdata == 8'hFF && hit_vec[7:0] == 8'h00)
      |=> (status_vec[7:0] == 8'h00));

  // R9: interrupt needs a pending status bit
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_vec != 16'h0));

  // R11: unmapped addresses read zero
  p_unmapped_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h50 || addr == 8'h3F || addr == 8'h4C) |-> (rdata == 8'h00));

  // R12: all pins are inputs when reset lifts
  p_oe_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == 16'h0));

endmodule

bind gpio_evt_ctrl gpio_evt_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .we         (reg_we),
  .addr       (reg_addr),
  .wdata      (reg_wdata),
  .rdata      (reg_rdata),
  .pin_oe     (pin_oe),
  .irq        (irq),
  .status_vec (stat_q),
  .hit_vec    (evt_hit)
);

// File: tb/test_gpio_evt_ctrl.sv
module test_gpio_evt_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [7:0]  addr_a = 8'h00, addr_b = 8'h00;
  logic [7:0]  wdata_a = 8'h00, wdata_b = 8'h00;
  logic [7:0]  rdata_a, rdata_b;
  logic [15:0] pin_in_a = 16'h0, pin_in_b = 16'h0;
  logic [15:0] pin_out_a, pin_out_b, pin_oe_a, pin_oe_b;
  logic        irq_a, irq_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int          q_sel[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_ctrl #(.PIN_COUNT(12), .SPLIT_OUT(1'b1)) i_gpio_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(we_a), .reg_addr(addr_a), .reg_wdata(wdata_a),
    .reg_rdata(rdata_a), .pin_in(pin_in_a), .pin_out(pin_out_a), .pin_oe(pin_oe_a), .irq(irq_a)
  );

  gpio_evt_ctrl #(.PIN_COUNT(16), .SPLIT_OUT(1'b0)) i_gpio_evt_ctrl_shared (
    .clk(clk), .rst_n(rst_n), .reg_we(we_b), .reg_addr(addr_b), .reg_wdata(wdata_b),
    .reg_rdata(rdata_b), .pin_in(pin_in_b), .pin_out(pin_out_b), .pin_oe(pin_oe_b), .irq(irq_b)
  );

  // Monitor: pops one expected item per negative edge and compares it.
  always @(negedge clk) begin
    while (q_sel.size() > 0) begin
      automatic int          s = q_sel.pop_front();
      automatic logic [15:0] e = q_exp.pop_front();
      automatic string       t = q_tag.pop_front();
      automatic logic [15:0] act;
      case (s)
        0:       act = {8'h00, rdata_a};
        1:       act = {15'h0, irq_a};
        2:       act = pin_oe_a;
        3:       act = pin_out_a;
        4:       act = {8'h00, rdata_b};
        default: act = pin_out_b;
      endcase
      n_cmp++;
      if (act !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  // Driver for checks: sel 0..3 observe instance A, 4..5 instance B.
  task automatic expect_val(input int sel, input logic [7:0] a, input logic [15:0] e,
                            input string tag);
    @(posedge clk); #1;
    if (sel >= 4) addr_b = a; else addr_a = a;
    q_sel.push_back(sel);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic wr(input bit inst_b, input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    if (inst_b) begin we_b = 1'b1; addr_b = a; wdata_b = d; end
    else        begin we_a = 1'b1; addr_a = a; wdata_a = d; end
    @(posedge clk); #1;
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    // R12: reset state while reset is held
    expect_val(0, 8'h40, 16'h00, "R12 dir reset");
    expect_val(0, 8'h44, 16'h00, "R12 status reset");
    expect_val(0, 8'h4A, 16'h00, "R12 ien reset");
    expect_val(0, 8'h47, 16'hF0, "R10 absent mode bits read one in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    idle(4);

    // R7: low pins in default low-level mode latch status
    expect_val(0, 8'h44, 16'hFF, "R7 low-level status lo");
    expect_val(0, 8'h45, 16'h0F, "R7 low-level status hi, absent pins zero");
    expect_val(1, 8'h00, 16'h0, "R9 no irq while disabled");

    // R2 / R3 / R1: direction, dedicated output, byte lanes
    wr(0, 8'h40, 8'hA5);
    wr(0, 8'h4E, 8'h3C);
    expect_val(2, 8'h00, 16'h00A5, "R2 pin_oe from direction");
    expect_val(3, 8'h00, 16'h003C, "R3 pin_out from own register");
    wr(0, 8'h41, 8'hFF);
    expect_val(0, 8'h40, 16'hA5, "R1 low lane kept after high write");
    expect_val(0, 8'h41, 16'h0F, "R10 absent direction bits read zero");
    expect_val(2, 8'h00, 16'h0FA5, "R2 upper outputs enabled");
    wr(0, 8'h42, 8'hFF);
    expect_val(0, 8'h4E, 16'h3C, "R3 level address write ignored");
    expect_val(3, 8'h00, 16'h003C, "R3 pin_out unchanged");

    // R5: synchronised line level
    pin_in_a = 16'h5A3C;
    idle(3);
    expect_val(0, 8'h42, 16'h3C, "R5 level lo");
    expect_val(0, 8'h43, 16'h0A, "R5 level hi masked");

    // R10: pin count discovery
    wr(0, 8'h46, 8'h00);
    wr(0, 8'h47, 8'h00);
    expect_val(0, 8'h47, 16'hF0, "R10 discovery lowest set bit 12");
    expect_val(0, 8'h46, 16'h00, "R10 implemented mode bits clear");

    // Configure: pin0 rising, pin1 falling, pins 2..11 high level
    pin_in_a = 16'h0000;
    idle(4);
    wr(0, 8'h46, 8'h03);
    wr(0, 8'h48, 8'hFD);
    wr(0, 8'h49, 8'hFF);
    wr(0, 8'h44, 8'hFF);
    wr(0, 8'h45, 8'hFF);
    expect_val(0, 8'h44, 16'h00, "R8 all-ones clear lo");
    expect_val(0, 8'h45, 16'h00, "R8 all-ones clear hi");

    // R6 rising
    pin_in_a = 16'h0001; idle(4);
    expect_val(0, 8'h44, 16'h01, "R6 rising edge sets");
    pin_in_a = 16'h0000; idle(4);
    wr(0, 8'h44, 8'h01);
    expect_val(0, 8'h44, 16'h00, "R6 falling on rising pin is no event");

    // R6 falling
    pin_in_a = 16'h0002; idle(4);
    expect_val(0, 8'h44, 16'h00, "R6 leading edge ignored on falling pin");
    pin_in_a = 16'h0000; idle(4);
    expect_val(0, 8'h44, 16'h02, "R6 falling edge sets");
    wr(0, 8'h44, 8'h00);
    expect_val(0, 8'h44, 16'h02, "R8 zero write leaves status");
    wr(0, 8'h44, 8'h02);
    expect_val(0, 8'h44, 16'h00, "R8 one write clears");

    // R7 level high re-sets after clear
    pin_in_a = 16'h0004; idle(4);
    wr(0, 8'h44, 8'h04);
    expect_val(0, 8'h44, 16'h04, "R7 held level re-sets after clear");
    pin_in_a = 16'h0000; idle(4);
    wr(0, 8'h44, 8'h04);
    expect_val(0, 8'h44, 16'h00, "R7 clear holds after level gone");

    // R9 interrupt
    pin_in_a = 16'h0001; idle(4);
    pin_in_a = 16'h0000; idle(2);
    expect_val(1, 8'h00, 16'h0, "R9 pending but disabled");
    wr(0, 8'h4A, 8'h01);
    expect_val(1, 8'h00, 16'h1, "R9 enabled pending raises irq");
    wr(0, 8'h4A, 8'h02);
    expect_val(1, 8'h00, 16'h0, "R9 other pin enabled only");
    wr(0, 8'h4A, 8'h01);
    wr(0, 8'h44, 8'h01);
    expect_val(1, 8'h00, 16'h0, "R9 irq drops after clear");

    // R11 unmapped
    wr(0, 8'h50, 8'hFF);
    wr(0, 8'h4C, 8'hFF);
    wr(0, 8'h3F, 8'hFF);
    expect_val(0, 8'h50, 16'h00, "R11 unmapped read 0x50");
    expect_val(0, 8'h4C, 16'h00, "R11 unmapped read 0x4C");
    expect_val(0, 8'h40, 16'hA5, "R11 direction untouched");
    expect_val(0, 8'h4A, 16'h01, "R11 enable untouched");

    // Shared-output, 16-pin build
    wr(1, 8'h46, 8'h00);
    wr(1, 8'h47, 8'h00);
    expect_val(4, 8'h47, 16'h00, "R10 full build reads zero");
    wr(1, 8'h47, 8'h5A);
    expect_val(4, 8'h47, 16'h5A, "R10 full build reads as written");
    wr(1, 8'h42, 8'h96);
    expect_val(5, 8'h00, 16'h0096, "R4 shared level write drives output");
    pin_in_b = 16'h0011; idle(3);
    expect_val(4, 8'h42, 16'h11, "R4 shared address reads level");
    wr(1, 8'h4E, 8'h77);
    expect_val(4, 8'h4E, 16'h00, "R4 dedicated address unmapped");
    expect_val(5, 8'h00, 16'h0096, "R4 output unchanged by 0x4E write");

    idle(2);
    done = 1'b1;
    finish_run();
  end

endmodule